// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus cycle early through a three-bit status code. It tracks the clock-state phase of the bus cycle on its own (T1, T2, T3, wait states, T4) and turns the status code into the command strobes that a local bus controller would drive. The strobes are memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also drives the address latch pulse, the data transceiver enable and the transceiver direction.

A cycle begins when the status leaves the passive code 111. This is seen at a rising edge while the decoder is idle or in T4. The cycle type is captured at that edge. The status returns to passive in T3, and the decoder then relies only on its own phase count and on READY to finish the cycle. The command outputs would be tri-state on a real pin. Here that is modelled by a separate enable that is high while a cycle is in progress.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released with passive status, all five command strobes are high (inactive), ale is 0, den is 0, dt_r is 1 and bus_oe is 0.
- R2: A status other than 111, seen at a rising edge where the previous edge saw 111 and the decoder is idle or in T4, starts a cycle. The clock that follows is T1, and ale is 1 in exactly that clock.
- R3: Each status code selects one active-low strobe. 000 selects inta_n. 001 selects io_rd_n. 010 selects io_wr_n. 100 (code fetch) and 101 (memory read) both select mem_rd_n. 110 selects mem_wr_n. 011 (halt) selects none. At most one strobe is low at any time.
- R4: The selected strobe is low in T2, T3 and every wait state. It is high in T1 and T4.
- R5: READY is sampled at the rising edge that ends T3 and each wait state. If it is low there, a wait state follows, and otherwise T4 follows. The strobe stays low throughout the wait states.
- R6: den is 1 in the same clocks as the command window of R4, for every cycle type except halt. No strobe is ever low while den is 0.
- R7: dt_r is 0 (receive) from T1 through T4 of a 000, 001, 100 or 101 cycle. It is 1 (transmit) in all other clocks, including write cycles, halt cycles and idle.
- R8: bus_oe is 1 from T1 through T4 of every cycle and 0 while idle.
- R9: The passive code 111 never starts a cycle. A non-passive code that has not been preceded by 111 at the previous edge does not start one either.
- R10: A new non-passive status presented during T4 starts the next cycle at once, so its T1 directly follows T4 with no idle clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stat | input | 3 | Processor bus cycle status code |
| ready | input | 1 | Active-high transfer ready |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| ale | output | 1 | Address latch pulse |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Transceiver direction, 1 transmit, 0 receive |
| bus_oe | output | 1 | Command output enable |

## Verification
Every output is a function of registered state only. A status change seen at a rising edge therefore shows up one clock later as ale, and two clocks later as the command strobe and den. A READY level sampled at the end of T3 decides whether the next clock is a wait state or T4. The bench drives status and READY on falling edges. A behavioural phase model advances on each rising edge, and every output is compared against it at the next falling edge, so each result is checked in exactly the clock where it is due. Directed sequences cover every code, several wait counts, back-to-back cycles and status that never returns to passive.

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_stat,
  input  logic       ready,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       inta_n,
  output logic       ale,
  output logic       den,
  output logic       dt_r,
  output logic       bus_oe
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} phase_t;

  localparam logic [2:0] ST_INTA = 3'b000;
  localparam logic [2:0] ST_IORD = 3'b001;
  localparam logic [2:0] ST_IOWR = 3'b010;
  localparam logic [2:0] ST_HALT = 3'b011;
  localparam logic [2:0] ST_CODE = 3'b100;
  localparam logic [2:0] ST_MRD  = 3'b101;
  localparam logic [2:0] ST_MWR  = 3'b110;
  localparam logic [2:0] ST_PASV = 3'b111;

  phase_t     st, st_nx;
  logic [2:0] stat_q, kind_q;

  wire begin_cyc = (bus_stat != ST_PASV) && (stat_q == ST_PASV) &&
                   (st == S_IDLE || st == S_T4);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (begin_cyc) st_nx = S_T1;
      S_T1:    st_nx = S_T2;
      S_T2:    st_nx = S_T3;
      S_T3,
      S_TW:    st_nx = ready ? S_T4 : S_TW;
      S_T4:    st_nx = begin_cyc ? S_T1 : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stat_q <= ST_PASV;
      kind_q <= ST_PASV;
    end else begin
      st     <= st_nx;
      stat_q <= bus_stat;
      if (begin_cyc) kind_q <= bus_stat;
    end
  end

  wire cmd_win = (st == S_T2) || (st == S_T3) || (st == S_TW);
  wire in_cyc  = (st != S_IDLE);
  wire rx_kind = (kind_q == ST_INTA) || (kind_q == ST_IORD) ||
                 (kind_q == ST_CODE) || (kind_q == ST_MRD);

  assign mem_rd_n = !(cmd_win && (kind_q == ST_CODE || kind_q == ST_MRD));
  assign mem_wr_n = !(cmd_win && kind_q == ST_MWR);
  assign io_rd_n  = !(cmd_win && kind_q == ST_IORD);
  assign io_wr_n  = !(cmd_win && kind_q == ST_IOWR);
  assign inta_n   = !(cmd_win && kind_q == ST_INTA);
  assign ale      = (st == S_T1);
  assign den      = cmd_win && (kind_q != ST_HALT);
  assign dt_r     = !(in_cyc && rx_kind);
  assign bus_oe   = in_cyc;

  wire [4:0] cmd_n = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n};

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cmd_n) <= 1);

  // R4
  ale_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (&cmd_n));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cmd_n) && !ale && !ready && st != S_T2) |=> ($stable(cmd_n) && den));

  // R6
  cmd_needs_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cmd_n) |-> den);

  // R7
  write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n || !io_wr_n) |-> dt_r);

  // R8
  ale_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> bus_oe);

endmodule

// File: tb/bus_cmd_decoder_tb.sv
`timescale 1ns/1ps
module bus_cmd_decoder_tb;
  logic clk = 0, rst_n = 1, ready = 1;
  logic [2:0] bus_stat = 3'b111;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n, ale, den, dt_r, bus_oe;

  always #4 clk = ~clk;

  bus_cmd_decoder u_dut (.clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .ready(ready),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .inta_n(inta_n), .ale(ale), .den(den), .dt_r(dt_r), .bus_oe(bus_oe));

  int checks = 0, fails = 0;
  bit chk_en = 0, done = 0;
  string ctx = "R1";

  // behavioural phase model: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  int ph = 0, ty = 7, prev = 7;

  always @(posedge clk) begin
    int nph;
    bit go;
    if (!rst_n) begin
      ph = 0; ty = 7; prev = 7;
    end else begin
      go = (bus_stat != 3'd7) && (prev == 7) && (ph == 0 || ph == 5);
      if (ph == 0) nph = go ? 1 : 0;
      else if (ph == 1 || ph == 2) nph = ph + 1;
      else if (ph == 3 || ph == 4) nph = ready ? 5 : 4;
      else nph = go ? 1 : 0;
      if (go) ty = bus_stat;
      prev = bus_stat;
      ph = nph;
    end
  end

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      bit win;
      logic [4:0] ecmd;
      win  = (ph >= 2 && ph <= 4);
      ecmd = 5'b11111;
      if (win) begin
        if (ty == 4 || ty == 5) ecmd[4] = 0;
        if (ty == 6) ecmd[3] = 0;
        if (ty == 1) ecmd[2] = 0;
        if (ty == 2) ecmd[1] = 0;
        if (ty == 0) ecmd[0] = 0;
      end
      check({ctx, " R3/R4 strobes"}, {4'b0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n}, {4'b0, ecmd});
      check({ctx, " R2 ale"}, {8'b0, ale}, {8'b0, ph == 1});
      check({ctx, " R6 den"}, {8'b0, den}, {8'b0, win && ty != 3});
      check({ctx, " R7 dt_r"}, {8'b0, dt_r},
            {8'b0, !(ph != 0 && (ty == 0 || ty == 1 || ty == 4 || ty == 5))});
      check({ctx, " R8 bus_oe"}, {8'b0, bus_oe}, {8'b0, ph != 0});
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    bus_stat = 3'b111; ready = 1;
    step(n);
  endtask

  task automatic bus_cycle(input logic [2:0] code, input int waits);
    bus_stat = code; ready = 1;
    step(3);
    bus_stat = 3'b111; ready = (waits == 0);
    step(1);
    for (int i = 0; i < waits; i++) begin
      ready = (i == waits - 1);
      step(1);
    end
    ready = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 0;
    step(1);
    ctx = "R1";
    chk_en = 1;
    step(3);
    rst_n = 1;
    idle(3);
    ctx = "R9";
    idle(4);
    ctx = "R3";
    for (int c = 0; c < 7; c++) begin
      bus_cycle(c[2:0], 0);
      idle(2);
    end
    ctx = "R5";
    bus_cycle(3'b101, 3); idle(2);
    bus_cycle(3'b010, 1); idle(2);
    bus_cycle(3'b000, 2); idle(2);
    ctx = "R10";
    bus_cycle(3'b110, 0);
    bus_cycle(3'b001, 0);
    bus_cycle(3'b100, 2);
    bus_cycle(3'b011, 0);
    idle(3);
    ctx = "R9";
    bus_stat = 3'b110; ready = 1;
    step(8);
    bus_stat = 3'b101;
    step(3);
    idle(2);
    bus_cycle(3'b101, 0);
    idle(3);
    ctx = "R1";
    rst_n = 0;
    step(2);
    rst_n = 1;
    idle(2);
    chk_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule